// File: doc/BRIEF.md
# Pin-Multiplexed General Purpose I/O Port

This block is a sixteen-pin I/O port controlled through a small memory-mapped register set. Each pin is either a software-controlled GPIO or is handed to one of four peripheral functions. A per-pin function-enable bit chooses between the two modes. A packed mux word holds a 2-bit selector for every pin. In peripheral mode, the chosen function drives the pad value and the pad output enable. The pad level is passed back to that function alone.

In GPIO mode, software controls the output latch and the pin direction through separate set and clear addresses, so no read-modify-write cycle is needed. A pin's direction can therefore be changed without disturbing its neighbours. A separate input-enable mask gates the input buffer. Pad levels pass through a two-stage synchronizer. They are then offered to the data readback, to the peripherals and to an interrupt-sense output.

Top module: `pinmux_gpio_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0, `pad_out` is 0, and `periph_in` and `pin_sense` are 0.
- R2: For a pin whose function-enable bit is 0, `pad_oe` equals its direction bit and `pad_out` equals its output-latch bit.
- R3: For a pin whose function-enable bit is 1, `pad_out` and `pad_oe` come from the function named by the mux word bits [2p+1:2p]. Function f owns bits [16f+15:16f] of `periph_out` and `periph_oe`.
- R4: A write to address 3 sets the output-latch bits where the write data is 1. A write to address 4 clears those bits. Bits written as 0 are unchanged, and a write of zero has no effect. Reads of address 3 or 4 return the latch.
- R5: A write to address 5 turns pins to outputs for every 1 bit. A write to address 6 turns them to inputs. Reading either address returns the direction mask, where 1 means output.
- R6: A write to address 5 also clears the input-enable bits of the pins it makes outputs. Address 7 reads and writes the input-enable mask directly.
- R7: A read of address 2 returns one bit per pin. An output pin returns its latch bit. An input pin with input enabled returns its synchronized pad level, which lags the pad by two clocks. Any other pin returns 0.
- R8: Bit 16f+p of `periph_in` carries pin p's synchronized level when that pin is function-enabled with selector f. Otherwise the bit is 0.
- R9: `pin_sense` equals the synchronized pad level ANDed with the input-enable mask.
- R10: `rdata` is registered. It carries the addressed register one clock after `rd_en` and holds while `rd_en` is low. Address 0 is the function-enable mask and address 1 is the 32-bit mux word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| periph_out | input | 64 | Output values of the four functions, 16 bits each |
| periph_oe | input | 64 | Output enables of the four functions, 16 bits each |
| periph_in | output | 64 | Synchronized pad levels routed to the four functions |
| pin_sense | output | 16 | Input-enabled synchronized levels for interrupt sensing |

## Verification
The hardest case to reach from the ports is a data readback that lands while pad levels are still moving through the synchronizer. The same case arises on a pin that software has re-enabled for input after it became an output. The bench toggles `pad_in` on every clock and issues reads on random cycles. Its cycle model keeps its own two-deep copy of the pad history. Directed steps set input enable after a direction-set write, which exercises the output-latch priority of the readback.

// File: rtl/pgp_pkg.sv
package pgp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FUNC  = 3'd0,
    A_MUX   = 3'd1,
    A_LEVEL = 3'd2,
    A_DSET  = 3'd3,
    A_DCLR  = 3'd4,
    A_OSET  = 3'd5,
    A_OCLR  = 3'd6,
    A_IEN   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pgp_sync.sv
module pgp_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgp_regs.sv
module pgp_regs
  import pgp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SEL_W    = 2,
  parameter int BUS_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BUS_W-1:0]          wdata,
  input  logic [NUM_PINS-1:0]       readback,
  output logic [BUS_W-1:0]          rdata,
  output logic [NUM_PINS-1:0]       func_en,
  output logic [NUM_PINS*SEL_W-1:0] mux,
  output logic [NUM_PINS-1:0]       data,
  output logic [NUM_PINS-1:0]       dir,
  output logic [NUM_PINS-1:0]       in_en
);
  localparam int MUX_W = NUM_PINS * SEL_W;

  function automatic logic [NUM_PINS-1:0] w1_set(logic [NUM_PINS-1:0] cur,
                                                 logic [NUM_PINS-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [NUM_PINS-1:0] w1_clr(logic [NUM_PINS-1:0] cur,
                                                 logic [NUM_PINS-1:0] m);
    return cur & ~m;
  endfunction

  logic [NUM_PINS-1:0] wbits;
  reg_addr_e           a_sel;
  logic [BUS_W-1:0]    rd_next;

  assign wbits = wdata[NUM_PINS-1:0];
  assign a_sel = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      func_en <= '0;
      mux     <= '0;
      data    <= '0;
      dir     <= '0;
      in_en   <= '0;
    end else if (wr_en) begin
      case (a_sel)
        A_FUNC: func_en <= wbits;
        A_MUX:  mux     <= wdata[MUX_W-1:0];
        A_DSET: data    <= w1_set(data, wbits);
        A_DCLR: data    <= w1_clr(data, wbits);
        A_OSET: begin
          dir   <= w1_set(dir, wbits);
          in_en <= w1_clr(in_en, wbits);
        end
        A_OCLR: dir     <= w1_clr(dir, wbits);
        A_IEN:  in_en   <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (a_sel)
      A_FUNC:         rd_next = BUS_W'(func_en);
      A_MUX:          rd_next = BUS_W'(mux);
      A_LEVEL:        rd_next = BUS_W'(readback);
      A_DSET, A_DCLR: rd_next = BUS_W'(data);
      A_OSET, A_OCLR: rd_next = BUS_W'(dir);
      A_IEN:          rd_next = BUS_W'(in_en);
      default:        rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/pgp_pin_route.sv
module pgp_pin_route #(
  parameter int NUM_PINS  = 16,
  parameter int NUM_FUNCS = 4,
  parameter int SEL_W     = 2
) (
  input  logic [NUM_PINS-1:0]           func_en,
  input  logic [NUM_PINS*SEL_W-1:0]     mux,
  input  logic [NUM_PINS-1:0]           data,
  input  logic [NUM_PINS-1:0]           dir,
  input  logic [NUM_PINS-1:0]           in_en,
  input  logic [NUM_PINS-1:0]           level,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_out,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_oe,
  output logic [NUM_FUNCS*NUM_PINS-1:0] periph_in,
  output logic [NUM_PINS-1:0]           pad_out,
  output logic [NUM_PINS-1:0]           pad_oe,
  output logic [NUM_PINS-1:0]           readback,
  output logic [NUM_PINS-1:0]           pin_sense
);
  function automatic logic pick_rb(logic is_out, logic latch, logic ien,
                                   logic lvl);
    return is_out ? latch : (ien & lvl);
  endfunction

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0]     sel;
    logic [NUM_FUNCS-1:0] fo;
    logic [NUM_FUNCS-1:0] fe;

    assign sel = mux[p*SEL_W +: SEL_W];

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      assign fo[f] = periph_out[f*NUM_PINS + p];
      assign fe[f] = periph_oe[f*NUM_PINS + p];
      assign periph_in[f*NUM_PINS + p] =
        level[p] & func_en[p] & (sel == SEL_W'(f));
    end

    always_comb begin
      if (func_en[p]) begin
        pad_out[p] = fo[sel];
        pad_oe[p]  = fe[sel];
      end else begin
        pad_out[p] = data[p];
        pad_oe[p]  = dir[p];
      end
    end

    assign readback[p]  = pick_rb(dir[p], data[p], in_en[p], level[p]);
    assign pin_sense[p] = level[p] & in_en[p];
  end
endmodule

// File: rtl/pinmux_gpio_port.sv
module pinmux_gpio_port
  import pgp_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int NUM_FUNCS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BUS_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BUS_W-1:0]              wdata,
  output logic [BUS_W-1:0]              rdata,
  input  logic [NUM_PINS-1:0]           pad_in,
  output logic [NUM_PINS-1:0]           pad_out,
  output logic [NUM_PINS-1:0]           pad_oe,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_out,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_oe,
  output logic [NUM_FUNCS*NUM_PINS-1:0] periph_in,
  output logic [NUM_PINS-1:0]           pin_sense
);
  localparam int SEL_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;
  localparam int MUX_W = NUM_PINS * SEL_W;

  logic [NUM_PINS-1:0] func_en_w;
  logic [MUX_W-1:0]    mux_w;
  logic [NUM_PINS-1:0] data_w;
  logic [NUM_PINS-1:0] dir_w;
  logic [NUM_PINS-1:0] ien_w;
  logic [NUM_PINS-1:0] lvl_w;
  logic [NUM_PINS-1:0] rb_w;

  pgp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_w)
  );

  pgp_regs #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .BUS_W(BUS_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .readback (rb_w),
    .rdata    (rdata),
    .func_en  (func_en_w),
    .mux      (mux_w),
    .data     (data_w),
    .dir      (dir_w),
    .in_en    (ien_w)
  );

  pgp_pin_route #(.NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .SEL_W(SEL_W)) u_route (
    .func_en    (func_en_w),
    .mux        (mux_w),
    .data       (data_w),
    .dir        (dir_w),
    .in_en      (ien_w),
    .level      (lvl_w),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .periph_in  (periph_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .readback   (rb_w),
    .pin_sense  (pin_sense)
  );
endmodule

// File: rtl/pgp_port_chk.sv
module pgp_port_chk
  import pgp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int BUS_W    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [BUS_W-1:0]    wdata,
  input logic [BUS_W-1:0]    rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pin_sense,
  input logic [NUM_PINS-1:0] func_en,
  input logic [NUM_PINS-1:0] dir,
  input logic [NUM_PINS-1:0] data,
  input logic [NUM_PINS-1:0] in_en
);
  logic [NUM_PINS-1:0] w;
  logic                wr_dset, wr_dclr, wr_oset;
  assign w       = wdata[NUM_PINS-1:0];
  assign wr_dset = wr_en && (addr == A_DSET);
  assign wr_dclr = wr_en && (addr == A_DCLR);
  assign wr_oset = wr_en && (addr == A_OSET);

  assert_data_set_R4: assert property (@(posedge clk) disable iff (rst)
    wr_dset |=> ((data & $past(w)) == $past(w)) &&
                ((data & ~$past(w)) == ($past(data) & ~$past(w))));

  assert_data_clr_R4: assert property (@(posedge clk) disable iff (rst)
    wr_dclr |=> ((data & $past(w)) == '0) &&
                ((data & ~$past(w)) == ($past(data) & ~$past(w))));

  assert_dir_set_R5: assert property (@(posedge clk) disable iff (rst)
    wr_oset |=> ((dir & $past(w)) == $past(w)));

  assert_ien_drop_R6: assert property (@(posedge clk) disable iff (rst)
    wr_oset |=> ((in_en & $past(w)) == '0));

  assert_gpio_oe_R2: assert property (@(posedge clk) disable iff (rst)
    ((~func_en) & (pad_oe ^ dir)) == '0);

  assert_sense_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (pin_sense & ~in_en) == '0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind pinmux_gpio_port pgp_port_chk #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .pad_oe    (pad_oe),
  .pin_sense (pin_sense),
  .func_en   (func_en_w),
  .dir       (dir_w),
  .data      (data_w),
  .in_en     (ien_w)
);

// File: tb/pinmux_gpio_port_bench.sv
module pinmux_gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pin_sense;
  logic [NF*NP-1:0] periph_out = '0, periph_oe = '0, periph_in;

  int total = 0;
  int bad = 0;
  bit started = 0;

  // behavioural model state
  logic [NP-1:0] m_func = '0, m_data = '0, m_dir = '0, m_ien = '0;
  logic [31:0]   m_mux = '0, m_rdata = '0;
  logic [NP-1:0] m_hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_gpio_port u_pinmux_gpio_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in), .pin_sense(pin_sense)
  );

  function automatic logic [NP-1:0] m_lvl();
    return (m_hist.size() >= 2) ? m_hist[0] : '0;
  endfunction

  function automatic int m_sel(int p);
    return (m_mux >> (2*p)) & 3;
  endfunction

  function automatic logic [NP-1:0] m_readback();
    logic [NP-1:0] r = '0;
    logic [NP-1:0] l = m_lvl();
    for (int p = 0; p < NP; p++) begin
      if (m_dir[p]) r[p] = m_data[p];
      else if (m_ien[p]) r[p] = l[p];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return {16'h0, m_func};
      1: return m_mux;
      2: return {16'h0, m_readback()};
      3, 4: return {16'h0, m_data};
      5, 6: return {16'h0, m_dir};
      default: return {16'h0, m_ien};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_func = '0; m_data = '0; m_dir = '0; m_ien = '0; m_mux = '0; m_rdata = '0;
      m_hist = {};
    end else begin
      if (rd_en) m_rdata = m_read(int'(addr));
      if (wr_en) begin
        case (int'(addr))
          0: m_func = wdata[15:0];
          1: m_mux = wdata;
          3: m_data = m_data | wdata[15:0];
          4: m_data = m_data & ~wdata[15:0];
          5: begin m_dir = m_dir | wdata[15:0]; m_ien = m_ien & ~wdata[15:0]; end
          6: m_dir = m_dir & ~wdata[15:0];
          7: m_ien = wdata[15:0];
          default: ;
        endcase
      end
      m_hist.push_back(pad_in);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
    end
    started = 1;
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      logic [NP-1:0] eo, ee;
      logic [NF*NP-1:0] epi;
      logic [NP-1:0] l;
      l = m_lvl();
      epi = '0;
      for (int p = 0; p < NP; p++) begin
        if (m_func[p]) begin
          eo[p] = periph_out[m_sel(p)*NP + p];
          ee[p] = periph_oe[m_sel(p)*NP + p];
          epi[m_sel(p)*NP + p] = l[p];
        end else begin
          eo[p] = m_data[p];
          ee[p] = m_dir[p];
        end
      end
      check("R2 gpio pad_out", 64'(pad_out & ~m_func), 64'(eo & ~m_func));
      check("R2 gpio pad_oe",  64'(pad_oe & ~m_func),  64'(ee & ~m_func));
      check("R3 periph pad_out", 64'(pad_out & m_func), 64'(eo & m_func));
      check("R3 periph pad_oe",  64'(pad_oe & m_func),  64'(ee & m_func));
      check("R8 periph_in", periph_in, epi);
      check("R9 pin_sense", 64'(pin_sense), 64'(l & m_ien));
      check("R10 rdata", 64'(rdata), 64'(m_rdata));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_exp(int a, logic [31:0] exp, string tag);
    rd_en = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    #1 check(tag, 64'(rdata), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 pad_oe after reset", 64'(pad_oe), 64'h0);
    check("R1 pad_out after reset", 64'(pad_out), 64'h0);
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd_exp(a, 32'h0, "R1 register reset");

    wr(7, 32'hFFFF);
    wr(5, 32'h00F0);
    rd_exp(7, 32'hFF0F, "R6 in_en dropped by dir set");
    rd_exp(5, 32'h00F0, "R5 dir via set address");
    rd_exp(6, 32'h00F0, "R5 dir via clear address");

    wr(3, 32'h1234);
    rd_exp(3, 32'h1234, "R4 data set");
    wr(4, 32'h0204);
    rd_exp(4, 32'h1030, "R4 data clear");
    wr(3, 32'h0);
    wr(4, 32'h0);
    rd_exp(3, 32'h1030, "R4 zero write ignored");
    check("R2 pad_out follows latch", 64'(pad_out), 64'h1030);
    check("R2 pad_oe follows dir", 64'(pad_oe), 64'h00F0);

    pad_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    check("R9 pin_sense", 64'(pin_sense), 64'hA503);
    rd_exp(2, 32'hA533, "R7 readback mix");
    wr(7, 32'h0);
    rd_exp(2, 32'h0030, "R7 disabled inputs read zero");
    wr(7, 32'h00F0);
    rd_exp(2, 32'h0030, "R7 output pin returns latch");

    periph_out = {16'h0008, 16'h0000, 16'h0002, 16'h0001};
    periph_oe  = {64{1'b1}};
    wr(1, 32'h0000_00E4);
    wr(0, 32'h000F);
    check("R3 pad_out from functions", 64'(pad_out), 64'h103B);
    check("R3 pad_oe from functions", 64'(pad_oe), 64'h00FF);
    check("R8 periph_in routing", periph_in, {16'h0, 16'h0, 16'h0002, 16'h0001});
    rd_exp(1, 32'h0000_00E4, "R10 mux readback");

    wr(6, 32'h00FF);
    rd_exp(5, 32'h0, "R5 dir cleared");
    pad_in = 16'h1111;
    repeat (3) @(negedge clk);
    check("R10 rdata held", 64'(rdata), 64'h0);

    for (int i = 0; i < 2000; i++) begin
      wr_en = 1'($urandom_range(0, 1));
      rd_en = 1'($urandom_range(0, 1));
      addr = 3'($urandom_range(0, 7));
      wdata = $urandom;
      pad_in = 16'($urandom);
      periph_out = {$urandom, $urandom};
      periph_oe = {$urandom, $urandom};
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule